// File: doc/BRIEF.md
# Phase-Correct PWM Timer with Prescaler

This block is an 8-bit timer that counts up from zero to its maximum and then back down to zero, over and over. The timer produces a symmetric (phase-correct) pulse-width-modulated waveform on a single output pin. A free-running divider feeds the counter. A 3-bit select input picks which tap of the divider gives the count enable, or stops the counter.

On each count enable the counter is compared with a compare register. A match raises a one-cycle flag that can serve as an interrupt request. Depending on a 2-bit output-mode field, the match also sets or clears the waveform level. Which of the two happens depends on whether the counter is rising or falling.

Software, or a surrounding register file, can write the counter value and the compare value directly. A counter write suppresses the compare on the following count enable, so that a loaded value does not produce a spurious match. When the compare value equals the maximum count and the output is driven, no level change occurs on an ordinary match. Instead, the falling-slope action is applied when the counter reaches the maximum.

Top module: `pwm_phase_timer`

## Requirements
- R1: After reset the following hold: the counter and the compare register are 0x00, the direction output is 1 (rising), the compare flag is 0 and the internal waveform level is 0.
- R2: The divider is 10 bits wide and free-running from reset. Count enables come from it according to the clock select, where clk_sel = 1..7 divides by 1, 8, 32, 64, 128, 256 and 1024. For a division of 2^k, an enable is asserted in each cycle where the low k divider bits are all ones. With clk_sel = 2 held from reset, the counter therefore first changes at the 8th rising clock edge after reset release.
- R3: With clk_sel = 0 no count enable is produced, and the counter holds its value.
- R4: On each enable the counter moves one step in its direction. At 0xFF while rising, it goes to 0xFE and turns to falling. At 0x00 while falling, it goes to 0x01 and turns to rising. count_up is 1 while rising.
- R5: A counter write loads cnt_wdata at that clock edge and overrides any step in the same cycle. The direction is unchanged.
- R6: cmp_flag is high for one cycle, right after a cycle in which an enable occurred, the counter equalled the compare register, and the compare was not suppressed.
- R7: For out_mode 00 and for out_mode 01 (reserved), wave_out equals port_in, and the internal waveform level is not changed by matches.
- R8: For out_mode 10, a match while rising clears the level and a match while falling sets it. out_mode 11 does the reverse. wave_out then shows the level, updated one cycle after the match cycle.
- R9: When the compare value is 0xFF and out_mode bit 1 is set, the match at the maximum count applies the falling-slope action: set for mode 10, clear for mode 11.
- R10: A counter write suppresses the compare in its own cycle and on the next enable after it.
- R11: A compare register write loads ocr_wdata at that edge. The new value is used by the compare from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| ocr_wr | input | 1 | Compare register write strobe |
| ocr_wdata | input | 8 | Compare register write value |
| out_mode | input | 2 | Waveform output mode |
| clk_sel | input | 3 | Count enable source select (0 = stopped) |
| port_in | input | 1 | Level the pin follows when the waveform is disconnected |
| cnt_q | output | 8 | Current counter value |
| ocr_q | output | 8 | Current compare value |
| count_up | output | 1 | 1 while counting up |
| cmp_flag | output | 1 | One-cycle compare match pulse |
| wave_out | output | 1 | Waveform pin level |

## Verification
The hardest situation to reach is a suppressed match: a counter write landing exactly on the compare value while the enables are continuous, so that the write cycle and the next enable would both otherwise compare. The bench loads the counter with the compare value at divide-by-1 and watches that no flag follows. The top-of-count special case is a second hard point, because it needs a full rising slope before its effect shows. Table scenarios at divide-by-1 run for more than one full period, so each slope end and the compare-at-maximum case are crossed in both output modes. A bench-side model of the stated rules is stepped in lockstep and compared every cycle.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

   // out_mode bit meanings
   localparam int unsigned OM_DRIVE_BIT = 1;   // 1: pin shows waveform level
   localparam int unsigned OM_POL_BIT   = 0;   // polarity of the rising-slope action

   typedef enum logic [1:0] {
      OM_PORT      = 2'b00,
      OM_RESERVED  = 2'b01,
      OM_CLR_RISE  = 2'b10,
      OM_SET_RISE  = 2'b11
   } out_mode_e;

   localparam int unsigned SEL_COUNT = 8;

   // number of low divider bits that must be all ones for a select value
   function automatic int unsigned tap_bits(input int unsigned sel);
      case (sel)
         1: tap_bits = 0;
         2: tap_bits = 3;
         3: tap_bits = 5;
         4: tap_bits = 6;
         5: tap_bits = 7;
         6: tap_bits = 8;
         7: tap_bits = 10;
         default: tap_bits = 0;
      endcase
   endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
   parameter int unsigned DIV_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   localparam int unsigned MAX_TAP = pwmt_pkg::tap_bits(pwmt_pkg::SEL_COUNT - 1);

   logic [DIV_W-1:0]                div_q;
   logic [pwmt_pkg::SEL_COUNT-1:0]  tap_hit;

   if (DIV_W < MAX_TAP) begin : g_bad_width
      $error("pwmt_prescaler: DIV_W too small for the slowest tap");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   assign tap_hit[0] = 1'b0;   // stopped

   for (genvar g = 1; g < pwmt_pkg::SEL_COUNT; g++) begin : g_tap
      localparam int unsigned   TB  = pwmt_pkg::tap_bits(g);
      localparam logic [DIV_W-1:0] MSK = DIV_W'((64'd1 << TB) - 64'd1);
      assign tap_hit[g] = ((div_q & MSK) == MSK);
   end

   assign tick = tap_hit[sel];

endmodule

// File: rtl/pwmt_updown.sv
module pwmt_updown #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cnt,
   output logic         up
);
   localparam logic [W-1:0] TOP    = {W{1'b1}};
   localparam logic [W-1:0] BOTTOM = '0;

   if (W < 2) begin : g_bad_width
      $error("pwmt_updown: W must be at least 2");
   end

   logic [W-1:0] cnt_d;
   logic         up_d;

   always_comb begin
      cnt_d = cnt;
      up_d  = up;
      if (wr) begin
         cnt_d = wdata;
      end else if (tick) begin
         if (up) begin
            if (cnt == TOP) begin
               cnt_d = TOP - 1'b1;
               up_d  = 1'b0;
            end else begin
               cnt_d = cnt + 1'b1;
            end
         end else begin
            if (cnt == BOTTOM) begin
               cnt_d = BOTTOM + 1'b1;
               up_d  = 1'b1;
            end else begin
               cnt_d = cnt - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= BOTTOM;
         up  <= 1'b1;
      end else begin
         cnt <= cnt_d;
         up  <= up_d;
      end
   end

endmodule

// File: rtl/pwmt_compare.sv
module pwmt_compare #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] ocr,
   input  logic         up,
   input  logic [1:0]   mode,
   output logic         flag,
   output logic         level
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic blk_q;
   logic hit;
   logic at_top_case;
   logic rising_eff;
   logic level_d;

   always_comb begin
      at_top_case = (ocr == TOP) && mode[pwmt_pkg::OM_DRIVE_BIT];
      hit         = tick && !wr && !blk_q && (cnt == ocr);
      rising_eff  = up && !at_top_case;
      level_d     = mode[pwmt_pkg::OM_POL_BIT] ^ ~rising_eff;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_q <= 1'b0;
         flag  <= 1'b0;
         level <= 1'b0;
      end else begin
         if (wr)        blk_q <= 1'b1;
         else if (tick) blk_q <= 1'b0;
         flag <= hit;
         if (hit && mode[pwmt_pkg::OM_DRIVE_BIT]) level <= level_d;
      end
   end

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer #(
   parameter int unsigned W     = 8,
   parameter int unsigned DIV_W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_wr,
   input  logic [W-1:0] cnt_wdata,
   input  logic         ocr_wr,
   input  logic [W-1:0] ocr_wdata,
   input  logic [1:0]   out_mode,
   input  logic [2:0]   clk_sel,
   input  logic         port_in,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] ocr_q,
   output logic         count_up,
   output logic         cmp_flag,
   output logic         wave_out
);
   logic tick_w;
   logic level_w;

   pwmt_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (clk_sel),
      .tick (tick_w)
   );

   pwmt_updown #(.W(W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_w),
      .wr   (cnt_wr),
      .wdata(cnt_wdata),
      .cnt  (cnt_q),
      .up   (count_up)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      ocr_q <= '0;
      else if (ocr_wr) ocr_q <= ocr_wdata;
   end

   pwmt_compare #(.W(W)) u_cmp (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_w),
      .wr   (cnt_wr),
      .cnt  (cnt_q),
      .ocr  (ocr_q),
      .up   (count_up),
      .mode (out_mode),
      .flag (cmp_flag),
      .level(level_w)
   );

   assign wave_out = out_mode[pwmt_pkg::OM_DRIVE_BIT] ? level_w : port_in;

endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         cnt_wr,
   input logic [W-1:0] cnt_wdata,
   input logic         ocr_wr,
   input logic [W-1:0] ocr_wdata,
   input logic [2:0]   clk_sel,
   input logic [W-1:0] cnt_q,
   input logic [W-1:0] ocr_q,
   input logic         count_up,
   input logic         cmp_flag
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt_q));

   a_r4_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count_up && cnt_q == TOP && !cnt_wr) |=> (!count_up && cnt_q == TOP - 1'b1));

   a_r4_turn_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !count_up && cnt_q == '0 && !cnt_wr) |=> (count_up && cnt_q == W'(1)));

   a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(cnt_wdata) && count_up == $past(count_up)));

   a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_flag |-> ($past(tick) && $past(cnt_q) == $past(ocr_q)));

   a_r10_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> !cmp_flag);

   a_r11_ocr_loads: assert property (@(posedge clk) disable iff (!rst_n)
      ocr_wr |=> ocr_q == $past(ocr_wdata));

endmodule

bind pwm_phase_timer pwm_phase_timer_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick_w),
   .cnt_wr   (cnt_wr),
   .cnt_wdata(cnt_wdata),
   .ocr_wr   (ocr_wr),
   .ocr_wdata(ocr_wdata),
   .clk_sel  (clk_sel),
   .cnt_q    (cnt_q),
   .ocr_q    (ocr_q),
   .count_up (count_up),
   .cmp_flag (cmp_flag)
);

// File: tb/pwm_phase_timer_test.sv
`timescale 1ns/1ps
module pwm_phase_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_wr = 1'b0;
   logic [7:0] cnt_wdata = '0;
   logic       ocr_wr = 1'b0;
   logic [7:0] ocr_wdata = '0;
   logic [1:0] out_mode = 2'b00;
   logic [2:0] clk_sel = 3'd0;
   logic       port_in = 1'b1;
   logic [7:0] cnt_q, ocr_q;
   logic       count_up, cmp_flag, wave_out;

   always #10 clk = ~clk;   // 50 MHz

   pwm_phase_timer uut (
      .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .ocr_wr(ocr_wr), .ocr_wdata(ocr_wdata), .out_mode(out_mode),
      .clk_sel(clk_sel), .port_in(port_in), .cnt_q(cnt_q), .ocr_q(ocr_q),
      .count_up(count_up), .cmp_flag(cmp_flag), .wave_out(wave_out)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference state, derived from the requirements
   int m_div, m_cnt, m_up, m_blk, m_flag, m_lvl, m_ocr;

   typedef struct packed {
      logic [2:0]  sel;
      logic [1:0]  mode;
      logic [7:0]  ocr;
      logic [7:0]  start;
      logic [15:0] cycles;
      logic        pin;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 2'b10, 8'h40, 8'h00, 16'd1100, 1'b0},   // R8 mode 10
      '{3'd1, 2'b11, 8'h80, 8'hF0, 16'd700,  1'b1},   // R8 mode 11, R4 top turn
      '{3'd2, 2'b10, 8'h10, 8'h08, 16'd4000, 1'b0},   // R2 divide by 8
      '{3'd1, 2'b10, 8'hFF, 8'h00, 16'd1100, 1'b0},   // R9 set at top
      '{3'd1, 2'b11, 8'hFF, 8'h20, 16'd1100, 1'b1},   // R9 clear at top
      '{3'd1, 2'b01, 8'h30, 8'h00, 16'd600,  1'b1},   // R7 reserved mode
      '{3'd0, 2'b10, 8'h00, 8'h33, 16'd300,  1'b0},   // R3 stopped
      '{3'd7, 2'b11, 8'h02, 8'h00, 16'd5000, 1'b0},   // R2 divide by 1024
      '{3'd4, 2'b10, 8'h05, 8'h03, 16'd3000, 1'b0}    // R2 divide by 64
   };

   function automatic int sel_mask(input int s);
      case (s)
         1: return 0;
         2: return 7;
         3: return 31;
         4: return 63;
         5: return 127;
         6: return 255;
         7: return 1023;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      int  s;
      bit  tk, hit;
      s   = int'(clk_sel);
      tk  = (s != 0) && ((m_div & sel_mask(s)) == sel_mask(s));
      hit = tk && !cnt_wr && (m_blk == 0) && (m_cnt == m_ocr);
      m_flag = hit;
      if (hit && out_mode[1])
         m_lvl = (out_mode == 2'b10) ? ((m_up == 1 && m_ocr != 255) ? 0 : 1)
                                     : ((m_up == 1 && m_ocr != 255) ? 1 : 0);
      if (cnt_wr) begin
         m_cnt = int'(cnt_wdata);
      end else if (tk) begin
         if (m_up == 1) begin
            if (m_cnt == 255) begin m_cnt = 254; m_up = 0; end
            else m_cnt++;
         end else begin
            if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
            else m_cnt--;
         end
      end
      if (cnt_wr) m_blk = 1;
      else if (tk) m_blk = 0;
      if (ocr_wr) m_ocr = int'(ocr_wdata);
      m_div = (m_div + 1) % 1024;
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic step(input bit cmp);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      if (cmp) begin
         check("R4/R5 counter", int'(cnt_q), m_cnt);
         check("R4 direction", int'(count_up), m_up);
         check("R6/R10 flag", int'(cmp_flag), m_flag);
         check("R11 compare reg", int'(ocr_q), m_ocr);
         check("R7/R8/R9 wave", int'(wave_out), out_mode[1] ? m_lvl : int'(port_in));
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cnt_wr = 1'b0; ocr_wr = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_div = 0; m_cnt = 0; m_up = 1; m_blk = 0; m_flag = 0; m_lvl = 0; m_ocr = 0;
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      port_in = 1'b1; out_mode = 2'b00; clk_sel = 3'd0;
      do_reset();
      check("R1 counter", int'(cnt_q), 0);
      check("R1 compare reg", int'(ocr_q), 0);
      check("R1 direction", int'(count_up), 1);
      check("R1 flag", int'(cmp_flag), 0);
      out_mode = 2'b10; #1;
      check("R1 level", int'(wave_out), 0);

      // R2: divide by 8 first changes the counter at the 8th edge
      out_mode = 2'b00; clk_sel = 3'd2;
      do_reset();
      repeat (7) step(1'b0);
      check("R2 before 8th edge", int'(cnt_q), 0);
      step(1'b0);
      check("R2 at 8th edge", int'(cnt_q), 1);

      // R6: match at count 3, divide by 1, flag one cycle later only
      clk_sel = 3'd0;
      do_reset();
      ocr_wr = 1'b1; ocr_wdata = 8'd3; step(1'b0); ocr_wr = 1'b0;
      clk_sel = 3'd1;
      repeat (3) step(1'b0);
      check("R6 no flag yet", int'(cmp_flag), 0);
      step(1'b0);
      check("R6 flag pulse", int'(cmp_flag), 1);
      step(1'b0);
      check("R6 flag one cycle", int'(cmp_flag), 0);

      // R10: loading the compare value suppresses its match
      do_reset();
      clk_sel = 3'd1; ocr_wr = 1'b1; ocr_wdata = 8'd5; step(1'b0); ocr_wr = 1'b0;
      cnt_wr = 1'b1; cnt_wdata = 8'd5; step(1'b0); cnt_wr = 1'b0;
      check("R10 write value", int'(cnt_q), 5);
      step(1'b0);
      check("R10 blocked flag", int'(cmp_flag), 0);
      step(1'b0);
      check("R10 still no flag", int'(cmp_flag), 0);
      check("R10 counter moved", int'(cnt_q), 7);

      // table walk against the reference model
      for (int i = 0; i < NV; i++) begin
         clk_sel = 3'd0; out_mode = VECS[i].mode; port_in = VECS[i].pin;
         do_reset();
         ocr_wr = 1'b1; ocr_wdata = VECS[i].ocr;
         cnt_wr = 1'b1; cnt_wdata = VECS[i].start;
         step(1'b1);
         ocr_wr = 1'b0; cnt_wr = 1'b0;
         clk_sel = VECS[i].sel;
         for (int c = 0; c < int'(VECS[i].cycles); c++) step(1'b1);
      end

      // R9 end state: constant high for mode 10 with compare at top
      clk_sel = 3'd0; out_mode = 2'b10; do_reset();
      ocr_wr = 1'b1; ocr_wdata = 8'hFF; step(1'b0); ocr_wr = 1'b0;
      clk_sel = 3'd1;
      repeat (600) step(1'b0);
      check("R9 level after top", int'(wave_out), 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule